// File: doc/BRIEF.md
# I2C Control and Status Register Target

This block sits on a two-wire serial bus as a target device and gives a bus host access to a small bank of registers. The registers control a neighbouring clock-recovery core, and the core's measurement results can be read back through them. The serial clock and data lines are sampled into the system clock domain. The block never drives the data line high: it only pulls it low, so the line can be wired-AND with other devices. A host writes one register by sending a sub-address byte and then a data byte. To read, the host first writes a sub-address, then issues a repeated START and switches to reading. It then collects as many bytes as it wants, and the sub-address steps by one after each byte.

The core sends in frequency count words, a 9-bit coarse rate value, a live loss-of-lock level and a measurement-done level. The block holds two sticky flags, loss-of-lock and measurement-complete. Each flag is cleared by writing a bit in a command register to 1 and then to 0. The same 1-then-0 pattern on another bit produces a one-clock system reset pulse. A configuration bit selects whether the loss-of-lock output follows the live input or the sticky flag.

Top module: `i2c_csr_target`

## Requirements
- R1: The 7-bit device address is {1, addrStrap, 00000}, so it is 0x60 with the strap high and 0x40 with the strap low. An address byte whose upper seven bits match is acknowledged: sdaDrvLow is held high through the ninth clock.
- R2: When the address does not match, the block never pulls SDA low before the next START. A write inside that transaction leaves every control output unchanged.
- R3: A write (START, address with R/W bit 0, sub-address, data, STOP) stores the data byte. At sub-address 0x08, bits 7:6 go to rangeSel, bits 5:2 to divRatio, bit 1 to measReq and bit 0 to lockToRef. At sub-address 0x11, bit 1 goes to squelchMode and bit 0 to outBoost.
- R4: A combined read returns the following for each sub-address: 0x00 gives freqWord0, 0x01 gives freqWord1, 0x02 gives {0, freqWord2}, and 0x03 gives coarseRate[8:1].
- R5: Sub-address 0x04 reads as a status byte. Bit 4 is the sticky loss-of-lock flag, bit 3 is the live lockLost input (1 = acquiring), bit 2 is the sticky measurement-complete flag and bit 0 is coarseRate[0]. Bits 7, 6, 5 and 1 read 0.
- R6: In a read, a master ACK after a byte makes the block send the byte at the next sub-address. A master NACK ends the transfer, and SDA stays released afterwards.
- R7: A read from any sub-address other than 0x00 to 0x04 returns 0x00. A write to a read-only or unmapped sub-address is acknowledged and has no effect.
- R8: The sticky loss-of-lock flag is set in any cycle where lockLost is 1. It holds until bit 6 of sub-address 0x09 is written as 1 and then as 0, and a set in the same cycle wins over the clear.
- R9: The sticky measurement-complete flag is set in any cycle where measDone is 1. It holds until bit 3 of sub-address 0x09 is written as 1 and then as 0.
- R10: While bit 7 of sub-address 0x09 is 0, lolOut follows lockLost. While that bit is 1, lolOut shows the sticky loss-of-lock flag.
- R11: Writing bit 5 of sub-address 0x09 as 1 and then as 0 raises sysResetPulse for exactly one clock. That pulse returns all writable registers and both sticky flags to 0.
- R12: After rstN, every control output, sysResetPulse and sdaDrvLow is 0. While lockLost is 0, lolOut is also 0.
- R13: sdaDrvLow changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Serial data line as seen at the pad |
| sdaDrvLow | output | 1 | 1 pulls the data line low, 0 releases it |
| addrStrap | input | 1 | Strap level for device address bit 5 |
| freqWord0 | input | 8 | Frequency count, low byte |
| freqWord1 | input | 8 | Frequency count, middle byte |
| freqWord2 | input | 7 | Frequency count, top bits |
| coarseRate | input | 9 | Coarse rate readback |
| lockLost | input | 1 | Live loss-of-lock, 1 = acquiring |
| measDone | input | 1 | Measurement finished |
| rangeSel | output | 2 | Reference range select |
| divRatio | output | 4 | Rate to reference divide ratio |
| measReq | output | 1 | Measurement request |
| lockToRef | output | 1 | 1 = lock to reference clock |
| squelchMode | output | 1 | Squelch mode select |
| outBoost | output | 1 | Output swing boost |
| sysResetPulse | output | 1 | One-clock system reset to the core |
| lolOut | output | 1 | Loss-of-lock indication, live or sticky |

## Verification
The bench targets the following corner cases:

- **Address mismatch followed by a write.** A design that decoded the address loosely would acknowledge the wrong address or apply the register write.
- **Read pointer handover.** A multi-byte read must start at the written sub-address, and the last byte must end with a NACK. A pointer that moved too early or too late would return shifted bytes, and a missed NACK would leave SDA held low.
- **The 1-then-0 command bits.** The bench checks that writing 1 alone clears nothing and that only the falling write acts. It also checks that the reset pulse lasts exactly one clock and that the sticky flags survive the end of lockLost. A level-triggered clear would lose the flag too early, and a wide reset pulse would show up in the pulse count.
- **Writes to read-only or unmapped sub-addresses.** The bench confirms these leave the status byte and the outputs unchanged.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } busState_t;

  typedef struct packed {
    logic              setPtr;
    logic              wrByte;
    logic              nextPtr;
    logic [BYTE_W-1:0] byteVal;
  } csrStrobe_t;
endpackage

// File: rtl/i2c_bus_ctrl.sv
module i2c_bus_ctrl
  import csr_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic       ADDR_MSB    = 1'b1,
  parameter logic [4:0] ADDR_LOW    = 5'b00000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrStrap,
  input  logic [BYTE_W-1:0] rdByte,
  output logic              sdaDrvLow,
  output csrStrobe_t        stb
);
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] END_CNT = CNT_W'(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclS, sdaS, sclPrev, sdaPrev;
  logic sclRise, sclFall, startDet, stopDet;
  busState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-2:0] txShift;
  logic readMode, masterNack;
  logic [BYTE_W-2:0] devAddr;

  assign sclS     = sclSync[SYNC_STAGES-1];
  assign sdaS     = sdaSync[SYNC_STAGES-1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign devAddr  = {ADDR_MSB, addrStrap, ADDR_LOW};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync    <= '1;
      sdaSync    <= '1;
      sclPrev    <= 1'b1;
      sdaPrev    <= 1'b1;
      state      <= ST_IDLE;
      bitCnt     <= '0;
      rxShift    <= '0;
      txShift    <= '0;
      readMode   <= 1'b0;
      masterNack <= 1'b0;
      sdaDrvLow  <= 1'b0;
      stb        <= '0;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
      stb     <= '0;
      if (startDet) begin
        state     <= ST_ADDR;
        bitCnt    <= '0;
        sdaDrvLow <= 1'b0;
      end else if (stopDet) begin
        state     <= ST_IDLE;
        bitCnt    <= '0;
        sdaDrvLow <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (sclRise) begin
              if (bitCnt < ACK_CNT) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
              if (bitCnt < END_CNT) bitCnt <= bitCnt + 1'b1;
            end else if (sclFall && bitCnt == ACK_CNT) begin
              if (state != ST_ADDR) begin
                sdaDrvLow   <= 1'b1;
                stb.byteVal <= rxShift;
                stb.setPtr  <= (state == ST_SUB);
                stb.wrByte  <= (state == ST_WDATA);
              end else if (rxShift[BYTE_W-1:1] == devAddr) begin
                sdaDrvLow <= 1'b1;
                readMode  <= rxShift[0];
              end else begin
                state <= ST_SKIP;
              end
            end else if (sclFall && bitCnt == END_CNT) begin
              bitCnt <= '0;
              if (state == ST_ADDR && readMode) begin
                state     <= ST_RDATA;
                txShift   <= rdByte[BYTE_W-2:0];
                sdaDrvLow <= ~rdByte[BYTE_W-1];
              end else begin
                sdaDrvLow <= 1'b0;
                state     <= (state == ST_ADDR) ? ST_SUB : ST_WDATA;
              end
            end
          end
          ST_RDATA: begin
            if (sclRise) begin
              if (bitCnt == ACK_CNT) masterNack <= sdaS;
              if (bitCnt < END_CNT) bitCnt <= bitCnt + 1'b1;
            end else if (sclFall) begin
              if (bitCnt != '0 && bitCnt < ACK_CNT) begin
                txShift   <= {txShift[BYTE_W-3:0], 1'b0};
                sdaDrvLow <= ~txShift[BYTE_W-2];
              end else if (bitCnt == ACK_CNT) begin
                sdaDrvLow   <= 1'b0;
                stb.nextPtr <= 1'b1;
              end else if (bitCnt == END_CNT) begin
                bitCnt <= '0;
                if (!masterNack) begin
                  txShift   <= rdByte[BYTE_W-2:0];
                  sdaDrvLow <= ~rdByte[BYTE_W-1];
                end else begin
                  state <= ST_SKIP;
                end
              end
            end
          end
          default: sdaDrvLow <= 1'b0;
        endcase
      end
    end
  end

  // R12
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> !sdaDrvLow);

  // R2
  skip_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> !sdaDrvLow);

  // R13
  sda_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && sclPrev) |-> $stable(sdaDrvLow));
endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] SUB_FREQ0 = 8'h00,
  parameter logic [BYTE_W-1:0] SUB_FREQ1 = 8'h01,
  parameter logic [BYTE_W-1:0] SUB_FREQ2 = 8'h02,
  parameter logic [BYTE_W-1:0] SUB_RATE  = 8'h03,
  parameter logic [BYTE_W-1:0] SUB_MISC  = 8'h04,
  parameter logic [BYTE_W-1:0] SUB_CTRLA = 8'h08,
  parameter logic [BYTE_W-1:0] SUB_CTRLB = 8'h09,
  parameter logic [BYTE_W-1:0] SUB_CTRLC = 8'h11,
  parameter int                COARSE_W  = BYTE_W + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  csrStrobe_t          stb,
  input  logic [BYTE_W-1:0]   freqWord0,
  input  logic [BYTE_W-1:0]   freqWord1,
  input  logic [BYTE_W-2:0]   freqWord2,
  input  logic [COARSE_W-1:0] coarseRate,
  input  logic                lockLost,
  input  logic                measDone,
  output logic [BYTE_W-1:0]   rdByte,
  output logic [1:0]          rangeSel,
  output logic [3:0]          divRatio,
  output logic                measReq,
  output logic                lockToRef,
  output logic                squelchMode,
  output logic                outBoost,
  output logic                sysResetPulse,
  output logic                lolOut
);
  localparam int B_LOLCFG  = 7;
  localparam int B_LOLCLR  = 6;
  localparam int B_SYSRST  = 5;
  localparam int B_MEASCLR = 3;

  logic [BYTE_W-1:0] ptr, ctrlA;
  logic cfgLolSticky, lolClrArm, rstArm, measClrArm;
  logic squelchReg, boostReg, stickyLol, measFlag;
  logic wrA, wrB, wrC, lolClrEvt, measClrEvt, rstEvt;

  assign wrA = stb.wrByte && (ptr == SUB_CTRLA);
  assign wrB = stb.wrByte && (ptr == SUB_CTRLB);
  assign wrC = stb.wrByte && (ptr == SUB_CTRLC);
  assign lolClrEvt  = wrB && lolClrArm  && !stb.byteVal[B_LOLCLR];
  assign measClrEvt = wrB && measClrArm && !stb.byteVal[B_MEASCLR];
  assign rstEvt     = wrB && rstArm     && !stb.byteVal[B_SYSRST];

  always_comb begin
    case (ptr)
      SUB_FREQ0: rdByte = freqWord0;
      SUB_FREQ1: rdByte = freqWord1;
      SUB_FREQ2: rdByte = {1'b0, freqWord2};
      SUB_RATE:  rdByte = coarseRate[COARSE_W-1:1];
      SUB_MISC:  rdByte = {3'b000, stickyLol, lockLost, measFlag, 1'b0, coarseRate[0]};
      default:   rdByte = '0;
    endcase
  end

  assign rangeSel    = ctrlA[7:6];
  assign divRatio    = ctrlA[5:2];
  assign measReq     = ctrlA[1];
  assign lockToRef   = ctrlA[0];
  assign squelchMode = squelchReg;
  assign outBoost    = boostReg;
  assign lolOut      = cfgLolSticky ? stickyLol : lockLost;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr           <= '0;
      ctrlA         <= '0;
      cfgLolSticky  <= 1'b0;
      lolClrArm     <= 1'b0;
      rstArm        <= 1'b0;
      measClrArm    <= 1'b0;
      squelchReg    <= 1'b0;
      boostReg      <= 1'b0;
      stickyLol     <= 1'b0;
      measFlag      <= 1'b0;
      sysResetPulse <= 1'b0;
    end else begin
      sysResetPulse <= rstEvt;
      if (stb.setPtr) ptr <= stb.byteVal;
      else if (stb.wrByte || stb.nextPtr) ptr <= ptr + 1'b1;
      if (sysResetPulse) begin
        ctrlA        <= '0;
        cfgLolSticky <= 1'b0;
        lolClrArm    <= 1'b0;
        rstArm       <= 1'b0;
        measClrArm   <= 1'b0;
        squelchReg   <= 1'b0;
        boostReg     <= 1'b0;
        stickyLol    <= 1'b0;
        measFlag     <= 1'b0;
      end else begin
        if (wrA) ctrlA <= stb.byteVal;
        if (wrB) begin
          cfgLolSticky <= stb.byteVal[B_LOLCFG];
          lolClrArm    <= stb.byteVal[B_LOLCLR];
          rstArm       <= stb.byteVal[B_SYSRST];
          measClrArm   <= stb.byteVal[B_MEASCLR];
        end
        if (wrC) begin
          squelchReg <= stb.byteVal[1];
          boostReg   <= stb.byteVal[0];
        end
        if (lockLost) stickyLol <= 1'b1;
        else if (lolClrEvt) stickyLol <= 1'b0;
        if (measDone) measFlag <= 1'b1;
        else if (measClrEvt) measFlag <= 1'b0;
      end
    end
  end

  // R11
  rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetPulse |=> !sysResetPulse);

  // R11
  sysrst_defaults_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(sysResetPulse) |-> (ctrlA == '0 && !cfgLolSticky && !squelchReg &&
                              !boostReg && !measFlag && !stickyLol));

  // R8
  lol_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(lockLost) && !$past(sysResetPulse)) |-> stickyLol);

  // R9
  meas_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(measDone) && !$past(sysResetPulse)) |-> measFlag);
endmodule

// File: rtl/i2c_csr_target.sv
module i2c_csr_target
  import csr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  input  logic              addrStrap,
  input  logic [BYTE_W-1:0] freqWord0,
  input  logic [BYTE_W-1:0] freqWord1,
  input  logic [BYTE_W-2:0] freqWord2,
  input  logic [BYTE_W:0]   coarseRate,
  input  logic              lockLost,
  input  logic              measDone,
  output logic [1:0]        rangeSel,
  output logic [3:0]        divRatio,
  output logic              measReq,
  output logic              lockToRef,
  output logic              squelchMode,
  output logic              outBoost,
  output logic              sysResetPulse,
  output logic              lolOut
);
  csrStrobe_t        stb;
  logic [BYTE_W-1:0] rdByte;

  i2c_bus_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .addrStrap (addrStrap),
    .rdByte    (rdByte),
    .sdaDrvLow (sdaDrvLow),
    .stb       (stb)
  );

  csr_regfile #(.COARSE_W(BYTE_W + 1)) uRegs (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .freqWord0     (freqWord0),
    .freqWord1     (freqWord1),
    .freqWord2     (freqWord2),
    .coarseRate    (coarseRate),
    .lockLost      (lockLost),
    .measDone      (measDone),
    .rdByte        (rdByte),
    .rangeSel      (rangeSel),
    .divRatio      (divRatio),
    .measReq       (measReq),
    .lockToRef     (lockToRef),
    .squelchMode   (squelchMode),
    .outBoost      (outBoost),
    .sysResetPulse (sysResetPulse),
    .lolOut        (lolOut)
  );
endmodule

// File: tb/sim_i2c_csr_target.sv
`timescale 1ns/1ps
module sim_i2c_csr_target;
  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h60;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclM, sdaMLow, addrStrap, lockLost, measDone;
  logic [7:0] freqWord0, freqWord1;
  logic [6:0] freqWord2;
  logic [8:0] coarseRate;
  logic sdaDrvLow, measReq, lockToRef, squelchMode, outBoost, sysResetPulse, lolOut;
  logic [1:0] rangeSel;
  logic [3:0] divRatio;
  logic sdaLine;
  assign sdaLine = !(sdaMLow || sdaDrvLow);

  int checks = 0;
  int fails = 0;
  int rstPulseCnt = 0;
  int sdaViol = 0;
  logic [7:0] rdBuf [8];
  logic [2:0] lastAcks;
  logic prevScl = 1'b1, prevDrv = 1'b0;

  i2c_csr_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaDrvLow(sdaDrvLow),
    .addrStrap(addrStrap), .freqWord0(freqWord0), .freqWord1(freqWord1),
    .freqWord2(freqWord2), .coarseRate(coarseRate), .lockLost(lockLost),
    .measDone(measDone), .rangeSel(rangeSel), .divRatio(divRatio), .measReq(measReq),
    .lockToRef(lockToRef), .squelchMode(squelchMode), .outBoost(outBoost),
    .sysResetPulse(sysResetPulse), .lolOut(lolOut)
  );

  always @(posedge clk) begin
    if (sysResetPulse) rstPulseCnt <= rstPulseCnt + 1;
    if (rstN && sclM && prevScl && (sdaDrvLow !== prevDrv)) sdaViol <= sdaViol + 1;
    prevScl <= sclM;
    prevDrv <= sdaDrvLow;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdaMLow = !b; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic recvBit(output logic b);
    sdaMLow = 1'b0; waitQ(); sclM = 1'b1; waitQ(); b = sdaLine; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStart();
    sdaMLow = 1'b0; sclM = 1'b1; waitQ(); sdaMLow = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busRestart();
    sdaMLow = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaMLow = 1'b1; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaMLow = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaMLow = 1'b0; waitQ(); waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic ack);
    logic bitv;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    recvBit(bitv);
    ack = !bitv;
  endtask

  task automatic readByte(output logic [7:0] v, input logic more);
    logic bitv;
    for (int i = 7; i >= 0; i--) begin
      recvBit(bitv);
      v[i] = bitv;
    end
    sendBit(!more);
  endtask

  task automatic regWrite(input logic [6:0] dev, input logic [7:0] sub, input logic [7:0] data);
    logic a0, a1, a2;
    busStart();
    writeByte({dev, 1'b0}, a0);
    writeByte(sub, a1);
    writeByte(data, a2);
    busStop();
    lastAcks = {a0, a1, a2};
  endtask

  task automatic regRead(input logic [6:0] dev, input logic [7:0] sub, input int n);
    logic a0, a1, a2;
    logic [7:0] v;
    busStart();
    writeByte({dev, 1'b0}, a0);
    writeByte(sub, a1);
    busRestart();
    writeByte({dev, 1'b1}, a2);
    for (int i = 0; i < n; i++) begin
      readByte(v, i != n - 1);
      rdBuf[i] = v;
    end
    busStop();
    lastAcks = {a0, a1, a2};
  endtask

  task automatic readMisc(input string req, input int exp);
    regRead(DEV, 8'h04, 1);
    chk(req, "status byte", rdBuf[0], exp);
  endtask

  task automatic testReset();
    chk("R12", "sdaDrvLow", sdaDrvLow, 0);
    chk("R12", "ctrl outputs", {rangeSel, divRatio, measReq, lockToRef, squelchMode, outBoost}, 0);
    chk("R12", "sysResetPulse/lolOut", {sysResetPulse, lolOut}, 0);
  endtask

  task automatic testCtrlWrite();
    regWrite(DEV, 8'h08, 8'h9B);
    chk("R1", "acks on write", lastAcks, 3'b111);
    chk("R3", "rangeSel", rangeSel, 2);
    chk("R3", "divRatio", divRatio, 6);
    chk("R3", "measReq/lockToRef", {measReq, lockToRef}, 2'b11);
    regWrite(DEV, 8'h11, 8'h02);
    chk("R3", "squelch/boost 0x02", {squelchMode, outBoost}, 2'b10);
    regWrite(DEV, 8'h11, 8'h03);
    chk("R3", "squelch/boost 0x03", {squelchMode, outBoost}, 2'b11);
  endtask

  task automatic testStatusRead();
    freqWord0 = 8'hA5; freqWord1 = 8'h3C; freqWord2 = 7'h7F; coarseRate = 9'h1B5;
    regRead(DEV, 8'h00, 5);
    chk("R1", "acks on read", lastAcks, 3'b111);
    chk("R4", "freq word 0", rdBuf[0], 8'hA5);
    chk("R4", "freq word 1", rdBuf[1], 8'h3C);
    chk("R4", "freq word 2", rdBuf[2], 8'h7F);
    chk("R4", "coarse high", rdBuf[3], 8'hDA);
    chk("R5", "status idle", rdBuf[4], 8'h01);
    chk("R6", "SDA released after NACK", sdaDrvLow, 0);
    coarseRate = 9'h0C2;
    regRead(DEV, 8'h03, 2);
    chk("R6", "start at 0x03", rdBuf[0], 8'h61);
    chk("R6", "next is 0x04", rdBuf[1], 8'h00);
    coarseRate = 9'h1B5;
  endtask

  task automatic testStickyLol();
    lockLost = 1'b1; repeat (5) @(negedge clk); lockLost = 1'b0; repeat (5) @(negedge clk);
    readMisc("R8", 8'h11);
    chk("R10", "lolOut live", lolOut, 0);
    regWrite(DEV, 8'h09, 8'h80);
    chk("R10", "lolOut sticky", lolOut, 1);
    regWrite(DEV, 8'h09, 8'hC0);
    chk("R8", "set bit alone keeps flag", lolOut, 1);
    regWrite(DEV, 8'h09, 8'h80);
    chk("R8", "1-then-0 clears flag", lolOut, 0);
    lockLost = 1'b1;
    readMisc("R5", 8'h19);
    lockLost = 1'b0; repeat (5) @(negedge clk);
    chk("R8", "flag held after lockLost drops", lolOut, 1);
    regWrite(DEV, 8'h09, 8'hC0);
    regWrite(DEV, 8'h09, 8'h00);
    lockLost = 1'b1; repeat (3) @(negedge clk);
    chk("R10", "lolOut follows live high", lolOut, 1);
    lockLost = 1'b0; repeat (3) @(negedge clk);
    chk("R10", "lolOut follows live low", lolOut, 0);
    regWrite(DEV, 8'h09, 8'h40);
    regWrite(DEV, 8'h09, 8'h00);
    readMisc("R8", 8'h01);
  endtask

  task automatic testMeasFlag();
    measDone = 1'b1; repeat (3) @(negedge clk); measDone = 1'b0;
    readMisc("R9", 8'h05);
    regWrite(DEV, 8'h09, 8'h08);
    readMisc("R9", 8'h05);
    regWrite(DEV, 8'h09, 8'h00);
    readMisc("R9", 8'h01);
  endtask

  task automatic testUnmapped();
    regRead(DEV, 8'h07, 1);
    chk("R7", "read 0x07", rdBuf[0], 0);
    regRead(DEV, 8'h08, 1);
    chk("R7", "read 0x08", rdBuf[0], 0);
    regWrite(DEV, 8'h04, 8'hFF);
    chk("R7", "acks on read-only write", lastAcks, 3'b111);
    readMisc("R7", 8'h01);
    regWrite(DEV, 8'h12, 8'hFF);
    regWrite(DEV, 8'h0A, 8'hFF);
    chk("R7", "outputs unchanged", {rangeSel, divRatio, measReq, lockToRef, squelchMode, outBoost}, 10'h26F);
  endtask

  task automatic testAddrMismatch();
    regWrite(7'h41, 8'h08, 8'h00);
    chk("R2", "no ack for 0x41", lastAcks, 3'b000);
    regWrite(7'h40, 8'h11, 8'h00);
    chk("R2", "no ack for 0x40 with strap high", lastAcks, 3'b000);
    chk("R2", "outputs unchanged", {rangeSel, divRatio, measReq, lockToRef, squelchMode, outBoost}, 10'h26F);
    addrStrap = 1'b0; repeat (4) @(negedge clk);
    regWrite(7'h40, 8'h11, 8'h01);
    chk("R1", "strap low ack 0x40", lastAcks, 3'b111);
    chk("R1", "write via 0x40", {squelchMode, outBoost}, 2'b01);
    regWrite(DEV, 8'h11, 8'h02);
    chk("R1", "0x60 ignored with strap low", lastAcks, 3'b000);
    chk("R2", "boost kept", {squelchMode, outBoost}, 2'b01);
    addrStrap = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic testSysReset();
    regWrite(DEV, 8'h09, 8'h80);
    lockLost = 1'b1; measDone = 1'b1; repeat (3) @(negedge clk);
    lockLost = 1'b0; measDone = 1'b0;
    regWrite(DEV, 8'h09, 8'hA0);
    chk("R11", "no pulse on 1 write", rstPulseCnt, 0);
    chk("R11", "lolOut before reset", lolOut, 1);
    regWrite(DEV, 8'h09, 8'h80);
    chk("R11", "single one-clock pulse", rstPulseCnt, 1);
    chk("R11", "ctrl outputs cleared", {rangeSel, divRatio, measReq, lockToRef, squelchMode, outBoost}, 0);
    chk("R11", "lolOut cleared", lolOut, 0);
    readMisc("R11", 8'h01);
  endtask

  initial begin
    rstN = 1'b0; sclM = 1'b1; sdaMLow = 1'b0; addrStrap = 1'b1;
    lockLost = 1'b0; measDone = 1'b0;
    freqWord0 = '0; freqWord1 = '0; freqWord2 = '0; coarseRate = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testCtrlWrite();
    testStatusRead();
    testStickyLol();
    testMeasFlag();
    testUnmapped();
    testAddrMismatch();
    testSysReset();
    chk("R13", "SDA changes while SCL high", sdaViol, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule